// File: doc/BRIEF.md
# Single-Clock FIFO with Direction Flag

This block is a synchronous first-in first-out queue with a parameterised number of entries and a parameterised data width. A producer presents a word together with a push strobe, and a consumer pops words with a pop strobe. Both strobes may be active in the same clock. Words leave the queue in the order they entered it.

Storage is a small register array addressed by two wrapping indices, one for the head and one for the tail. When the two indices are equal, the queue is either completely full or completely empty. A single stored bit tells these two cases apart. The bit is set by the most recent successful push and cleared by the most recent successful pop. The full and empty outputs are decoded combinationally from the indices and this bit; no separate flag registers exist.

Popped data is registered. It appears on the output one clock after the pop is accepted, and it holds its value between pops.

Top module: `dirflag_fifo`

## Requirements
- R1: After reset both indices are 0 and the direction bit reads "last was pop", so `empty`=1 and `full`=0.
- R2: An accepted push (`push`=1 and `full`=0) stores `wdata` at the tail index. The tail index then advances by one and wraps from DEPTH-1 to 0.
- R3: An accepted pop (`pop`=1 and `empty`=0) loads the entry at the head index into `rdata` on that clock edge. The head index then advances by one with the same wrap. Words come out in the order they were pushed.
- R4: `full` is 1 exactly when the indices are equal and the last successful operation was a push. `empty` is 1 exactly when the indices are equal and the last successful operation was a pop. Both are combinational.
- R5: A push while `full`=1 is ignored. Storage, the tail index and the direction bit are unchanged, and the words popped afterwards do not include the rejected word.
- R6: A pop while `empty`=1 is ignored. The head index and the direction bit are unchanged, and `rdata` keeps its previous value.
- R7: When a push and a pop are both accepted in the same clock, both indices advance and the direction bit keeps its value, so the occupancy stays the same.
- R8: `rdata` changes only on a clock edge where a pop is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Write request |
| wdata | input | WIDTH | Word to be written |
| pop | input | 1 | Read request |
| rdata | output | WIDTH | Registered read word |
| full | output | 1 | Queue holds DEPTH words |
| empty | output | 1 | Queue holds no words |

## Verification
A directed fill-to-full and drain-to-empty sequence checks that equal indices are decoded as full after pushes and as empty after pops. This is the case the direction bit exists to resolve. Pushes against a full queue and pops against an empty one show that rejected requests leave no trace in the later output stream or in `rdata`. A long run of random simultaneous push/pop traffic crosses the wrap point many times. It separates correct ordering and unchanged occupancy under concurrent operations from designs that mishandle the direction bit when both ports act in the same clock.

// File: rtl/dirflag_fifo.sv
module dirflag_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] head, tail;
  logic last_push;

  wire same  = (head == tail);
  assign full  = same &  last_push;
  assign empty = same & ~last_push;

  wire do_push = push & ~full;
  wire do_pop  = pop  & ~empty;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[tail] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      last_push <= 1'b0;
      rdata     <= '0;
    end else begin
      if (do_push) tail <= step(tail);
      if (do_pop) begin
        head  <= step(head);
        rdata <= mem[head];
      end
      if (do_push != do_pop) last_push <= do_push;
    end
  end
endmodule

module dirflag_fifo_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic             pop,
  input logic [WIDTH-1:0] rdata,
  input logic             full,
  input logic             empty
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else cnt <= cnt + CW'(push & ~full) - CW'(pop & ~empty);
  end

  a_r4_not_both: assert property (@(posedge clk) disable iff (!rst_n) !(full && empty));
  a_r4_full_count: assert property (@(posedge clk) disable iff (!rst_n) full == (cnt == CW'(DEPTH)));
  a_r4_empty_count: assert property (@(posedge clk) disable iff (!rst_n) empty == (cnt == '0));
  a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> empty && !full);
  a_r7_both_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> ($stable(full) && $stable(empty)));
  a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> (empty && $stable(rdata)));
  a_r5_full_push: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pop && !empty) && $past(rst_n)) |=> $stable(rdata));
endmodule

bind dirflag_fifo dirflag_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
  .rdata(rdata), .full(full), .empty(empty));

// File: tb/dirflag_fifo_test.sv
module dirflag_fifo_test;
  localparam int W = 8;
  localparam int D = 5;
  localparam int TCLK = 10;

  logic clk = 0, rst_n = 0, push = 0, pop = 0;
  logic [W-1:0] wdata = 0;
  logic [W-1:0] rdata;
  logic full, empty;

  int checks = 0, fails = 0;
  logic [W-1:0] model[$];
  logic [W-1:0] expq[$];
  logic [W-1:0] last_rd = 0;
  logic pend = 0;

  always #(TCLK/2) clk = ~clk;

  dirflag_fifo #(.WIDTH(W), .DEPTH(D)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: one clock after an accepted pop, compare against the scoreboard
  always @(negedge clk) begin
    if (pend) begin
      pend = 0;
      if (expq.size() > 0) begin
        last_rd = expq.pop_front();
        check("R3 order", rdata, last_rd);
      end
    end else if (rst_n) begin
      check("R8 hold", rdata, last_rd);
    end
  end

  // driver: drive at negedge, resolve model at posedge
  task automatic cyc(input logic p, input logic [W-1:0] d, input logic r);
    logic ef, ff;
    @(negedge clk);
    #1;
    push = p; wdata = d; pop = r;
    ef = (model.size() == 0); ff = (model.size() == D);
    #1;
    check("R4 empty", empty, ef);
    check("R4 full", full, ff);
    @(posedge clk);
    if (r && !ef) begin expq.push_back(model.pop_front()); pend = 1; end
    if (p && !ff) model.push_back(d);
  endtask

  initial begin
    #(TCLK*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    rst_n = 1;
    // R6: pop on empty is ignored
    cyc(0, 0, 1); cyc(0, 0, 1);
    // R2/R4: fill to full
    for (int i = 0; i < D; i++) cyc(1, W'(8'h10 + i), 0);
    // R5: pushes while full are dropped
    cyc(1, 8'hEE, 0); cyc(1, 8'hEF, 0);
    // R7: simultaneous while full -> only pop accepted
    cyc(1, 8'hDD, 1);
    cyc(1, 8'h40, 1); // both accepted, occupancy stays D-1
    // drain to empty, then extra pops (R6)
    for (int i = 0; i < D + 2; i++) cyc(0, 0, 1);
    // random traffic, R7 and wrap
    for (int i = 0; i < 3000; i++) cyc($urandom_range(0,1) == 1, W'($urandom), $urandom_range(0,2) != 0);
    for (int i = 0; i < 3000; i++) cyc($urandom_range(0,2) != 0, W'($urandom), $urandom_range(0,1) == 1);
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    check("R3 drained", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule